// File: doc/BRIEF.md
# Interrupt Aggregator with Per-Line Polarity and Edge/Level Capture

This block gathers a group of external interrupt request lines into a single active-high, level-sensitive request for a parent interrupt controller. Each raw line first passes through a two-flop synchronizer. Its own polarity bit then decides whether high or low counts as active. The result is captured into a status bit. A global control register chooses between level capture and edge capture, and holds a master enable that gates the combined output.

Software reaches the block over a plain 32-bit register bus: byte address, write strobe, write data and combinational read data. There is no handshake, so a write takes effect on the clock edge where the strobe is high, and reads return data in the same cycle. Status bits are cleared by writing ones to a dedicated clear register. The parent request is high whenever the master enable is set and at least one line is both enabled and pending. The default build has 18 lines, with lines 0 to 15 as the primary set. The line count must stay below 32.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the control register reads 0, the enable register reads 0, the status register reads 0, the polarity register reads 1 in every line bit (all lines active-high), and irq_out is low.
- R2: Registers sit at byte offsets 0x00 control, 0x04 enable, 0x08 status, 0x0C clear and 0x10 polarity. Bit n of the enable, status, clear and polarity registers belongs to line n. Address bits 1:0 are ignored. Writes to status are ignored, and the clear register always reads 0.
- R3: Unused bits read as 0: control bits 29:0, and bits 31:18 of the line registers. Any offset other than the five above reads 0.
- R4: A raw input that becomes active before rising edge k is reflected in status after rising edge k+2 and not before, because of the two synchronizer stages.
- R5: A polarity bit of 1 makes its line active when the input is high. A polarity bit of 0 makes it active when the input is low.
- R6: With control bit 30 at 0 (level mode), a status bit is set on every edge where its synchronized line is active. It then stays set after the line goes inactive, until it is cleared.
- R7: With control bit 30 at 1 (edge mode), a status bit is set only when the synchronized, polarity-adjusted line changes from inactive to active. A line held active does not set the bit again after a clear.
- R8: A write to the clear register clears every status bit written as 1 and leaves bits written as 0 unchanged. If a bit's set condition holds on the same edge as its clear, the set wins and the bit stays set.
- R9: irq_out is high exactly when control bit 31 is 1 and the AND of enable and status is nonzero. It follows the registers with no extra cycle of delay.
- R10: While control bit 31 (master enable) is 0, irq_out stays low whatever status and enable hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | input | 18 | Raw asynchronous interrupt request lines |
| irq_out | output | 1 | Combined level-sensitive request to the parent, active high |

## Verification
Every cycle, the assertions check three things. The master enable keeps irq_out low when it is off. irq_out never rises without an enabled pending line, and always rises when there is one. A status bit never falls unless the previous edge carried a write to the clear register. The bench scenarios cover what a property cannot: the three-edge capture latency, the opposite sense of the polarity bits, edge mode refusing to re-latch a line held active, a set that collides with its own clear, and the zeros at unused bits and offsets. A cycle-level reference model then follows thousands of cycles of random writes and random line activity.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned CSR_W      = 32;
  // word indices (byte offset >> 2)
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_ENABLE = 1;
  localparam int unsigned IDX_STATUS = 2;
  localparam int unsigned IDX_CLEAR  = 3;
  localparam int unsigned IDX_POLAR  = 4;
  // control register fields
  localparam int unsigned BIT_MASTER = 31;
  localparam int unsigned BIT_EDGE   = 30;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_ENABLE, SEL_STATUS, SEL_CLEAR, SEL_POLAR, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqagg_line.sv
module irqagg_line #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic active_high,
  input  logic edge_mode,
  input  logic clr,
  output logic pending
);
  logic synced;
  logic active;
  logic active_d;
  logic set_cond;

  irqagg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  assign active   = active_high ? synced : ~synced;
  assign set_cond = edge_mode ? (active & ~active_d) : active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_d <= 1'b0;
      pending  <= 1'b0;
    end else begin
      active_d <= active;
      // a set on the same edge outranks the clear
      pending  <= set_cond | (pending & ~clr);
    end
  end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 18,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [CSR_W-1:0]     bus_wdata,
  output logic [CSR_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] status,
  output logic                 master_en,
  output logic                 edge_mode,
  output logic [NUM_LINES-1:0] enable,
  output logic [NUM_LINES-1:0] polarity,
  output logic [NUM_LINES-1:0] clr_mask
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned PAD_W  = CSR_W - NUM_LINES;

  logic [WIDX_W-1:0] widx;
  reg_sel_e          sel;
  logic              unused_bus;

  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_bus = ^{bus_addr[1:0], bus_wdata};

  always_comb begin
    if      (widx == WIDX_W'(IDX_CTRL))   sel = SEL_CTRL;
    else if (widx == WIDX_W'(IDX_ENABLE)) sel = SEL_ENABLE;
    else if (widx == WIDX_W'(IDX_STATUS)) sel = SEL_STATUS;
    else if (widx == WIDX_W'(IDX_CLEAR))  sel = SEL_CLEAR;
    else if (widx == WIDX_W'(IDX_POLAR))  sel = SEL_POLAR;
    else                                  sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0;
      edge_mode <= 1'b0;
      enable    <= '0;
      polarity  <= '1;
    end else if (bus_wr) begin
      case (sel)
        SEL_CTRL: begin
          master_en <= bus_wdata[BIT_MASTER];
          edge_mode <= bus_wdata[BIT_EDGE];
        end
        SEL_ENABLE: enable   <= bus_wdata[NUM_LINES-1:0];
        SEL_POLAR:  polarity <= bus_wdata[NUM_LINES-1:0];
        default: ;
      endcase
    end
  end

  assign clr_mask = (bus_wr && sel == SEL_CLEAR) ? bus_wdata[NUM_LINES-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        bus_rdata[BIT_MASTER] = master_en;
        bus_rdata[BIT_EDGE]   = edge_mode;
      end
      SEL_ENABLE: bus_rdata = {{PAD_W{1'b0}}, enable};
      SEL_STATUS: bus_rdata = {{PAD_W{1'b0}}, status};
      SEL_POLAR:  bus_rdata = {{PAD_W{1'b0}}, polarity};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 18,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [CSR_W-1:0]     bus_wdata,
  output logic [CSR_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] irq_req,
  output logic                 irq_out
);
  logic                 master_en;
  logic                 edge_mode;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] pol_q;
  logic [NUM_LINES-1:0] clr_mask;
  logic [NUM_LINES-1:0] stat_vec;

  irqagg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status    (stat_vec),
    .master_en (master_en),
    .edge_mode (edge_mode),
    .enable    (en_q),
    .polarity  (pol_q),
    .clr_mask  (clr_mask)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irqagg_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk         (clk),
      .rst         (rst),
      .raw         (irq_req[i]),
      .active_high (pol_q[i]),
      .edge_mode   (edge_mode),
      .clr         (clr_mask[i]),
      .pending     (stat_vec[i])
    );
  end

  assign irq_out = master_en & |(en_q & stat_vec);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 18,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic                 irq_out,
  input logic                 master,
  input logic [NUM_LINES-1:0] enable,
  input logic [NUM_LINES-1:0] status
);
  logic                 prev_clr_wr;
  logic [NUM_LINES-1:0] prev_status;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clr_wr <= 1'b0;
      prev_status <= '0;
    end else begin
      prev_clr_wr <= bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_CLEAR));
      prev_status <= status;
    end
  end

  a_r10_master_gates: assert property (@(posedge clk) disable iff (rst)
    !master |-> !irq_out);

  a_r9_out_needs_pending: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (enable & status) != '0);

  a_r9_pending_raises_out: assert property (@(posedge clk) disable iff (rst)
    (master && (enable & status) != '0) |-> irq_out);

  a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    !prev_clr_wr |-> (status & prev_status) == prev_status);

  a_r1_enable_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (enable == '0 && !irq_out));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .irq_out  (irq_out),
  .master   (master_en),
  .enable   (en_q),
  .status   (stat_vec)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int N = 18;
  localparam logic [31:0] ALL = 32'h0003_FFFF;
  localparam logic [7:0] A_CTRL = 8'h00, A_EN = 8'h04, A_STAT = 8'h08,
                         A_CLR = 8'h0C, A_POL = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_req = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_aggregator dut (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .irq_req (irq_req), .irq_out (irq_out)
  );

  // ---------------- reference model ----------------
  logic         m_master, m_edge;
  logic [N-1:0] m_en, m_pol, m_stat, m_s1, m_s2, m_prev;

  always @(posedge clk) begin
    logic [N-1:0] act, setv, clrv;
    if (rst) begin
      m_master = 0; m_edge = 0; m_en = '0; m_pol = '1;
      m_stat = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
    end else begin
      act  = (m_pol & m_s2) | (~m_pol & ~m_s2);
      setv = m_edge ? (act & ~m_prev) : act;
      clrv = (bus_wr && bus_addr[7:2] == 6'd3) ? bus_wdata[N-1:0] : '0;
      m_stat = setv | (m_stat & ~clrv);
      m_prev = act;
      m_s2 = m_s1;
      m_s1 = irq_req;
      if (bus_wr) begin
        case (bus_addr[7:2])
          6'd0: begin m_master = bus_wdata[31]; m_edge = bus_wdata[30]; end
          6'd1: m_en  = bus_wdata[N-1:0];
          6'd4: m_pol = bus_wdata[N-1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a[7:2])
      6'd0: return {m_master, m_edge, 30'b0};
      6'd1: return {14'b0, m_en};
      6'd2: return {14'b0, m_stat};
      6'd4: return {14'b0, m_pol};
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_master && ((m_en & m_stat) != '0);
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    rd_reg(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd_reg(A_EN, v);   chk("R1 enable", v, 32'h0);
    rd_reg(A_STAT, v); chk("R1 status", v, 32'h0);
    rd_reg(A_POL, v);  chk("R1 polarity", v, ALL);
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // level mode setup
    wr_reg(A_CTRL, 32'h8000_0000);
    wr_reg(A_EN, ALL);
    tick(4);
    wr_reg(A_CLR, ALL);
    rd_reg(A_STAT, v); chk("R6 quiet status", v, 32'h0);

    // R4 latency: active before edge 1, visible after edge 3
    @(negedge clk); irq_req[3] = 1'b1;
    tick(2);
    rd_reg(A_STAT, v); chk("R4 not yet after two edges", v, 32'h0);
    tick(1);
    rd_reg(A_STAT, v); chk("R4 set after third edge", v, 32'h8);
    chk("R9 irq with pending", {31'b0, irq_out}, 32'h1);

    // R6/R8 clear while still active loses, then holds after inactive
    wr_reg(A_CLR, 32'h8);
    rd_reg(A_STAT, v); chk("R6 clear while active", v, 32'h8);
    irq_req[3] = 1'b0;
    tick(4);
    rd_reg(A_STAT, v); chk("R6 held after inactive", v, 32'h8);
    wr_reg(A_CLR, 32'h8);
    rd_reg(A_STAT, v); chk("R8 clear inactive line", v, 32'h0);
    chk("R9 irq idle", {31'b0, irq_out}, 32'h0);

    // R8 zero bits leave status alone
    irq_req[5] = 1'b1; irq_req[6] = 1'b1;
    tick(4);
    irq_req[5] = 1'b0; irq_req[6] = 1'b0;
    tick(4);
    wr_reg(A_CLR, 32'h20);
    rd_reg(A_STAT, v); chk("R8 partial clear", v, 32'h40);
    wr_reg(A_CLR, ALL);

    // R5 active-low line with low input
    wr_reg(A_POL, ALL & ~32'h80);
    tick(4);
    rd_reg(A_STAT, v); chk("R5 active-low sets", v, 32'h80);
    wr_reg(A_CLR, ALL);
    rd_reg(A_STAT, v); chk("R5 still active low", v, 32'h80);
    wr_reg(A_POL, ALL);
    wr_reg(A_CLR, ALL);
    rd_reg(A_STAT, v); chk("R5 active-high idle", v, 32'h0);

    // R7 edge mode
    wr_reg(A_CTRL, 32'hC000_0000);
    irq_req[2] = 1'b1;
    tick(4);
    rd_reg(A_STAT, v); chk("R7 edge latched", v, 32'h4);
    wr_reg(A_CLR, 32'h4);
    rd_reg(A_STAT, v); chk("R7 no relatch on steady", v, 32'h0);
    tick(3);
    rd_reg(A_STAT, v); chk("R7 still clear", v, 32'h0);
    irq_req[2] = 1'b0;
    tick(4);
    // R8 edge lands on the same edge as its clear
    @(negedge clk); irq_req[2] = 1'b1;
    tick(2);
    bus_addr = A_CLR; bus_wr = 1'b1; bus_wdata = 32'h4;
    tick(1);
    bus_wr = 1'b0;
    rd_reg(A_STAT, v); chk("R8 set beats clear", v, 32'h4);

    // R9 / R10 output gating
    chk("R9 irq on", {31'b0, irq_out}, 32'h1);
    wr_reg(A_CTRL, 32'h4000_0000);
    chk("R10 master off", {31'b0, irq_out}, 32'h0);
    wr_reg(A_CTRL, 32'hC000_0000);
    chk("R10 master back on", {31'b0, irq_out}, 32'h1);
    wr_reg(A_EN, ALL & ~32'h4);
    chk("R9 masked line", {31'b0, irq_out}, 32'h0);
    wr_reg(A_EN, ALL);

    // R2 map details
    wr_reg(A_STAT, 32'h0);
    rd_reg(A_STAT, v); chk("R2 status write ignored", v, 32'h4);
    rd_reg(A_CLR, v);  chk("R2 clear reads zero", v, 32'h0);
    rd_reg(8'h07, v);  chk("R2 low address bits ignored", v, ALL);
    rd_reg(8'h03, v);  chk("R2 ctrl alias", v, 32'hC000_0000);

    // R3 unused bits and offsets
    rd_reg(8'h14, v); chk("R3 unmapped 0x14", v, 32'h0);
    rd_reg(8'hFC, v); chk("R3 unmapped 0xFC", v, 32'h0);
    wr_reg(A_CTRL, 32'hFFFF_FFFF);
    rd_reg(A_CTRL, v); chk("R3 ctrl unused bits", v, 32'hC000_0000);
    wr_reg(A_EN, 32'hFFFF_FFFF);
    rd_reg(A_EN, v); chk("R3 enable unused bits", v, ALL);
    wr_reg(A_POL, 32'hFFFF_FFFF);
    rd_reg(A_POL, v); chk("R3 polarity unused bits", v, ALL);

    // random phase against the model (R2 R3 R5 R6 R7 R8 R9 R10)
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      chk("R9 random irq_out", {31'b0, irq_out}, {31'b0, exp_irq()});
      irq_req = N'($urandom);
      if (($urandom % 4) == 0) begin
        int sel;
        sel = $urandom % 6;
        bus_addr  = {3'b0, sel[2:0], 2'(($urandom % 4))};
        bus_wr    = 1'b1;
        bus_wdata = $urandom;
        if (sel == 0) bus_wdata[31] = ($urandom % 4) != 0;
      end else begin
        bus_wr   = 1'b0;
        bus_addr = {3'b0, 3'(($urandom % 6)), 2'(($urandom % 4))};
        #1;
        chk("R3 random read", bus_rdata, exp_read(bus_addr));
      end
    end
    @(negedge clk);
    bus_wr = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule